// File: doc/BRIEF.md
# Operand Address Generator

This block forms the data-memory operand address for a 16-bit fixed-point signal processor. It keeps eight pointer registers, two step registers, a base register, a ring-start register and a ring-length register. Each cycle the instruction decoder presents an addressing mode with its selects, and the block answers within that cycle with one effective address. When the mode calls for it, the chosen pointer is advanced in the same cycle as a side effect of the transfer.

Pointers can advance linearly by a small immediate (+1, 0, -1, -2) or by a signed step register. They can also advance inside a ring whose bounds come from the ring-start and ring-length registers. A separate direct mode adds a 7-bit displacement to the base register and leaves every pointer alone. All registers are loaded through one write port, and that port takes precedence over a pointer advance aimed at the same register in the same cycle.

Top module: `opaddr_gen`

## Requirements
- R1: After reset every register (pointers, steps, base, ring start, ring length) reads zero, and `ea_valid` equals `req_valid` in the same cycle.
- R2: Mode 0: `ea` is pointer `req_ptr`. At the clock edge that pointer gains the immediate step coded by `req_step` as 2-bit two's complement (01 = +1, 00 = 0, 11 = -1, 10 = -2), modulo 2^16.
- R3: Mode 1: `ea` is pointer `req_ptr`. At the clock edge that pointer gains step register `req_upd`, modulo 2^16.
- R4: Mode 2: `ea` is the base register plus `req_disp` zero-extended, modulo 2^16, and no pointer changes.
- R5: Modes 3 (immediate step coded as in R2) and 4 (step register taken as signed): `ea` is the pointer. The sum s = pointer + step is computed without wrap. The new pointer is s - len if s > start + len - 1, s + len if s < start, else s, and only its low 16 bits are kept.
- R6: In modes 3 and 4 with ring length zero, the pointer keeps its value.
- R7: Write port: `wr_sel` 0-7 loads a pointer, 8-9 a step register, 10 the base, 11 the ring start, 12 the ring length; codes 13-15 change nothing. The new value is used from the next cycle on.
- R8: A load through the write port into the pointer being advanced in the same cycle wins over the advance.
- R9: With `req_valid` low, or with a reserved mode 5-7, no pointer changes. In reserved modes `ea` is pointer `req_ptr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register load strobe |
| wr_sel | input | 4 | Register chosen for loading |
| wr_data | input | 16 | Value loaded |
| req_valid | input | 1 | Address request this cycle |
| req_mode | input | 3 | Addressing mode |
| req_ptr | input | 3 | Pointer select |
| req_step | input | 2 | Immediate step code |
| req_upd | input | 1 | Step register select |
| req_disp | input | 7 | Direct displacement |
| ea | output | 16 | Effective address |
| ea_valid | output | 1 | Effective address is meaningful |

## Verification
The hardest cases to reach are the ring boundaries: a pointer that sits exactly at the ring top or bottom while the step carries it just across, and a load colliding with an advance of the same pointer. Random stimulus rarely lines these up. Directed sequences therefore load a short ring, place the pointer on each edge and step across in both directions, then issue a load and an advance to the same pointer in one cycle. A long random phase favours small ring lengths so that wraps occur often, and every result is read back as an address.

// File: rtl/opaddr_pkg.sv
package opaddr_pkg;

   typedef enum logic [2:0] {
      AM_POST_IMM = 3'd0,
      AM_POST_UPD = 3'd1,
      AM_DIRECT   = 3'd2,
      AM_CIRC_IMM = 3'd3,
      AM_CIRC_UPD = 3'd4
   } addr_mode_e;

   localparam int unsigned STEP_CODE_W = 2;

endpackage

// File: rtl/opaddr_regfile.sv
module opaddr_regfile #(
   parameter int unsigned AW   = 16,
   parameter int unsigned NPTR = 8,
   parameter int unsigned NUPD = 2,
   localparam int unsigned PSW = (NPTR > 1) ? $clog2(NPTR) : 1,
   localparam int unsigned NREG = NPTR + NUPD + 3,
   localparam int unsigned WSW = $clog2(NREG)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [WSW-1:0]       wr_sel,
   input  logic [AW-1:0]        wr_data,
   input  logic                 pu_en,
   input  logic [PSW-1:0]       pu_idx,
   input  logic [AW-1:0]        pu_val,
   output logic [NPTR*AW-1:0]   ptr_bus,
   output logic [NUPD*AW-1:0]   upd_bus,
   output logic [AW-1:0]        bp_q,
   output logic [AW-1:0]        bv_q,
   output logic [AW-1:0]        md_q
);

   localparam int unsigned SEL_BP = NPTR + NUPD;
   localparam int unsigned SEL_BV = NPTR + NUPD + 1;
   localparam int unsigned SEL_MD = NPTR + NUPD + 2;

   for (genvar g = 0; g < NPTR; g++) begin : g_ptr
      logic [AW-1:0] q;
      wire hit_wr = wr_en && (wr_sel == WSW'(g));
      wire hit_pu = pu_en && (pu_idx == PSW'(g));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      q <= '0;
         else if (hit_wr) q <= wr_data;
         else if (hit_pu) q <= pu_val;
      end
      assign ptr_bus[g*AW +: AW] = q;
   end

   for (genvar u = 0; u < NUPD; u++) begin : g_upd
      logic [AW-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                   q <= '0;
         else if (wr_en && wr_sel == WSW'(NPTR + u))   q <= wr_data;
      end
      assign upd_bus[u*AW +: AW] = q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bp_q <= '0;
         bv_q <= '0;
         md_q <= '0;
      end else if (wr_en) begin
         if (wr_sel == WSW'(SEL_BP)) bp_q <= wr_data;
         if (wr_sel == WSW'(SEL_BV)) bv_q <= wr_data;
         if (wr_sel == WSW'(SEL_MD)) md_q <= wr_data;
      end
   end

endmodule

// File: rtl/opaddr_wrap.sv
module opaddr_wrap #(
   parameter int unsigned AW      = 16,
   parameter bit          CIRC_EN = 1'b1
) (
   input  logic [AW-1:0] cur,
   input  logic [AW-1:0] delta,
   input  logic          ring,
   input  logic [AW-1:0] ring_base,
   input  logic [AW-1:0] ring_len,
   output logic [AW-1:0] nxt
);

   localparam int unsigned EW = AW + 2;

   logic [AW-1:0] lin_sum;
   assign lin_sum = cur + delta;

   if (CIRC_EN) begin : g_circ
      logic signed [EW-1:0] sum_w, top_w, base_w, len_w, adj_w;
      always_comb begin
         sum_w  = $signed({2'b00, cur}) + $signed({{2{delta[AW-1]}}, delta});
         base_w = $signed({2'b00, ring_base});
         len_w  = $signed({2'b00, ring_len});
         top_w  = base_w + len_w - EW'(1);
         if (sum_w > top_w)       adj_w = sum_w - len_w;
         else if (sum_w < base_w) adj_w = sum_w + len_w;
         else                     adj_w = sum_w;
         if (!ring)               nxt = lin_sum;
         else if (ring_len == '0) nxt = cur;
         else                     nxt = adj_w[AW-1:0];
      end
   end else begin : g_lin
      logic unused_ok;
      assign unused_ok = ring ^ (^ring_base) ^ (^ring_len);
      assign nxt = lin_sum;
   end

endmodule

// File: rtl/opaddr_next.sv
module opaddr_next
   import opaddr_pkg::*;
#(
   parameter int unsigned AW      = 16,
   parameter bit          CIRC_EN = 1'b1
) (
   input  logic [2:0]             mode,
   input  logic [AW-1:0]          cur,
   input  logic [STEP_CODE_W-1:0] step_code,
   input  logic [AW-1:0]          upd_val,
   input  logic [AW-1:0]          ring_base,
   input  logic [AW-1:0]          ring_len,
   output logic [AW-1:0]          nxt,
   output logic                   wb_en
);

   logic [AW-1:0] imm_ext, delta;
   logic          use_upd, ring;

   assign imm_ext = {{(AW-STEP_CODE_W){step_code[STEP_CODE_W-1]}}, step_code};

   always_comb begin
      use_upd = 1'b0;
      ring    = 1'b0;
      wb_en   = 1'b1;
      unique case (mode)
         AM_POST_IMM: ;
         AM_POST_UPD: use_upd = 1'b1;
         AM_CIRC_IMM: ring = 1'b1;
         AM_CIRC_UPD: begin use_upd = 1'b1; ring = 1'b1; end
         default:     wb_en = 1'b0;
      endcase
   end

   assign delta = use_upd ? upd_val : imm_ext;

   opaddr_wrap #(.AW(AW), .CIRC_EN(CIRC_EN)) wrap_i (
      .cur      (cur),
      .delta    (delta),
      .ring     (ring),
      .ring_base(ring_base),
      .ring_len (ring_len),
      .nxt      (nxt)
   );

endmodule

// File: rtl/opaddr_gen.sv
module opaddr_gen
   import opaddr_pkg::*;
#(
   parameter int unsigned AW      = 16,
   parameter int unsigned NPTR    = 8,
   parameter int unsigned NUPD    = 2,
   parameter int unsigned DISPW   = 7,
   parameter bit          CIRC_EN = 1'b1,
   localparam int unsigned PSW  = (NPTR > 1) ? $clog2(NPTR) : 1,
   localparam int unsigned USW  = (NUPD > 1) ? $clog2(NUPD) : 1,
   localparam int unsigned WSW  = $clog2(NPTR + NUPD + 3)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr_en,
   input  logic [WSW-1:0]         wr_sel,
   input  logic [AW-1:0]          wr_data,
   input  logic                   req_valid,
   input  logic [2:0]             req_mode,
   input  logic [PSW-1:0]         req_ptr,
   input  logic [STEP_CODE_W-1:0] req_step,
   input  logic [USW-1:0]         req_upd,
   input  logic [DISPW-1:0]       req_disp,
   output logic [AW-1:0]          ea,
   output logic                   ea_valid
);

   if (AW < 8)            begin : g_bad_aw   $error("AW too small");            end
   if (DISPW >= AW)       begin : g_bad_disp $error("DISPW must be below AW");  end
   if (NPTR < 1)          begin : g_bad_np   $error("NPTR must be positive");   end
   if (NUPD < 1)          begin : g_bad_nu   $error("NUPD must be positive");   end

   logic [NPTR*AW-1:0] ptr_bus;
   logic [NUPD*AW-1:0] upd_bus;
   logic [AW-1:0]      bp_q, bv_q, md_q;
   logic [AW-1:0]      cur_ptr, upd_val, nxt_ptr;
   logic               wb_en;

   assign cur_ptr = ptr_bus[req_ptr*AW +: AW];
   assign upd_val = upd_bus[req_upd*AW +: AW];

   opaddr_next #(.AW(AW), .CIRC_EN(CIRC_EN)) next_i (
      .mode     (req_mode),
      .cur      (cur_ptr),
      .step_code(req_step),
      .upd_val  (upd_val),
      .ring_base(bv_q),
      .ring_len (md_q),
      .nxt      (nxt_ptr),
      .wb_en    (wb_en)
   );

   opaddr_regfile #(.AW(AW), .NPTR(NPTR), .NUPD(NUPD)) rf_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_en),
      .wr_sel (wr_sel),
      .wr_data(wr_data),
      .pu_en  (req_valid && wb_en),
      .pu_idx (req_ptr),
      .pu_val (nxt_ptr),
      .ptr_bus(ptr_bus),
      .upd_bus(upd_bus),
      .bp_q   (bp_q),
      .bv_q   (bv_q),
      .md_q   (md_q)
   );

   always_comb begin
      if (req_mode == AM_DIRECT) ea = bp_q + {{(AW-DISPW){1'b0}}, req_disp};
      else                       ea = cur_ptr;
   end

   assign ea_valid = req_valid;

endmodule

// File: rtl/opaddr_gen_chk.sv
module opaddr_gen_chk #(
   parameter int unsigned AW   = 16,
   parameter int unsigned NPTR = 8,
   parameter int unsigned PSW  = 3,
   parameter int unsigned WSW  = 4
) (
   input logic                clk,
   input logic                rst_n,
   input logic                wr_en,
   input logic [WSW-1:0]      wr_sel,
   input logic [AW-1:0]       wr_data,
   input logic                req_valid,
   input logic [2:0]          req_mode,
   input logic [PSW-1:0]      req_ptr,
   input logic [1:0]          req_step,
   input logic [AW-1:0]       ea,
   input logic [AW-1:0]       bv_q,
   input logic [AW-1:0]       md_q,
   input logic [NPTR*AW-1:0]  ptr_bus
);

   logic           imm_c, circ_c, ld_c;
   logic [PSW-1:0] imm_sel, circ_sel;
   logic [WSW-1:0] ld_sel;
   logic [AW-1:0]  imm_exp, ld_val, circ_lo;
   logic [AW:0]    circ_hi;
   logic           wr_same;
   logic [AW-1:0]  step_ext;

   assign wr_same  = wr_en && (wr_sel == WSW'(req_ptr));
   assign step_ext = {{(AW-2){req_step[1]}}, req_step};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         imm_c <= 1'b0; circ_c <= 1'b0; ld_c <= 1'b0;
         imm_sel <= '0; circ_sel <= '0; ld_sel <= '0;
         imm_exp <= '0; ld_val <= '0; circ_lo <= '0; circ_hi <= '0;
      end else begin
         imm_c   <= req_valid && req_mode == 3'd0 && !wr_same;
         imm_sel <= req_ptr;
         imm_exp <= ea + step_ext;
         ld_c    <= wr_en && (wr_sel < WSW'(NPTR));
         ld_sel  <= wr_sel;
         ld_val  <= wr_data;
         circ_c  <= req_valid && req_mode == 3'd3 && !wr_same && md_q >= AW'(2)
                    && ({1'b0, bv_q} + {1'b0, md_q} <= {1'b1, {AW{1'b0}}})
                    && ea >= bv_q && ({1'b0, ea} < {1'b0, bv_q} + {1'b0, md_q});
         circ_sel <= req_ptr;
         circ_lo  <= bv_q;
         circ_hi  <= {1'b0, bv_q} + {1'b0, md_q};
      end
   end

   logic [AW-1:0] imm_now, ld_now, circ_now;
   assign imm_now  = ptr_bus[imm_sel*AW +: AW];
   assign ld_now   = ptr_bus[ld_sel[PSW-1:0]*AW +: AW];
   assign circ_now = ptr_bus[circ_sel*AW +: AW];

   a_r2_imm_step: assert property (@(posedge clk) disable iff (!rst_n)
      imm_c |-> imm_now == imm_exp);

   a_r8_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
      ld_c |-> ld_now == ld_val);

   a_r5_stays_in_ring: assert property (@(posedge clk) disable iff (!rst_n)
      circ_c |-> (circ_now >= circ_lo && {1'b0, circ_now} < circ_hi));

   a_r4_direct_keeps_ptrs: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_mode == 3'd2 && !wr_en) |=> $stable(ptr_bus));

   a_r9_idle_keeps_ptrs: assert property (@(posedge clk) disable iff (!rst_n)
      (!req_valid && !wr_en) |=> $stable(ptr_bus));

endmodule

bind opaddr_gen opaddr_gen_chk #(.AW(AW), .NPTR(NPTR), .PSW(PSW), .WSW(WSW)) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .wr_en    (wr_en),
   .wr_sel   (wr_sel),
   .wr_data  (wr_data),
   .req_valid(req_valid),
   .req_mode (req_mode),
   .req_ptr  (req_ptr),
   .req_step (req_step),
   .ea       (ea),
   .bv_q     (bv_q),
   .md_q     (md_q),
   .ptr_bus  (ptr_bus)
);

// File: tb/opaddr_gen_tb.sv
`timescale 1ns/1ps
module opaddr_gen_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [3:0]  wr_sel = '0;
   logic [15:0] wr_data = '0;
   logic        req_valid = 1'b0;
   logic [2:0]  req_mode = '0;
   logic [2:0]  req_ptr = '0;
   logic [1:0]  req_step = '0;
   logic [0:0]  req_upd = '0;
   logic [6:0]  req_disp = '0;
   logic [15:0] ea;
   logic        ea_valid;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #4 clk = ~clk;

   opaddr_gen dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .req_valid(req_valid), .req_mode(req_mode), .req_ptr(req_ptr),
      .req_step(req_step), .req_upd(req_upd), .req_disp(req_disp),
      .ea(ea), .ea_valid(ea_valid)
   );

   logic [15:0] mx [8];
   logic [15:0] my [2];
   logic [15:0] mbp, mbv, mmd;

   function automatic longint step_of(input logic [2:0] m, input logic [1:0] s,
                                      input logic [15:0] yv);
      if (m == 3'd1 || m == 3'd4) return longint'($signed(yv));
      return longint'($signed(s));
   endfunction

   function automatic logic [15:0] next_ptr(input logic [2:0] m, input logic [15:0] cur,
         input logic [1:0] s, input logic [15:0] yv, input logic [15:0] bv,
         input logic [15:0] len);
      longint sum, top;
      sum = longint'(cur) + step_of(m, s, yv);
      if (m == 3'd0 || m == 3'd1) return sum[15:0];
      if (len == 16'd0) return cur;
      top = longint'(bv) + longint'(len) - 1;
      if (sum > top) sum = sum - longint'(len);
      else if (sum < longint'(bv)) sum = sum + longint'(len);
      return sum[15:0];
   endfunction

   function automatic logic [15:0] exp_ea(input logic [2:0] m, input logic [2:0] p,
                                          input logic [6:0] d);
      if (m == 3'd2) return mbp + {9'd0, d};
      return mx[p];
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
      checks++;
      if (act !== expv) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, expv);
      end
   endtask

   function automatic string tag_of(input logic [2:0] m);
      case (m)
         3'd0: return "R2";
         3'd1: return "R3";
         3'd2: return "R4";
         3'd3, 3'd4: return (mmd == 0) ? "R6" : "R5";
         default: return "R9";
      endcase
   endfunction

   task automatic cyc(input bit we, input logic [3:0] ws, input logic [15:0] wd,
                      input bit rv, input logic [2:0] m, input logic [2:0] p,
                      input logic [1:0] s, input logic [0:0] u, input logic [6:0] d);
      @(negedge clk);
      wr_en = we; wr_sel = ws; wr_data = wd;
      req_valid = rv; req_mode = m; req_ptr = p; req_step = s; req_upd = u; req_disp = d;
      #2;
      check("R1", {31'd0, ea_valid}, {31'd0, rv});
      if (rv) check(tag_of(m), {16'd0, ea}, {16'd0, exp_ea(m, p, d)});
      if (rv && m <= 3'd4 && m != 3'd2)
         mx[p] = next_ptr(m, mx[p], s, my[u], mbv, mmd);
      if (we) begin
         if (ws < 4'd8)       mx[ws[2:0]] = wd;
         else if (ws == 4'd8) my[0] = wd;
         else if (ws == 4'd9) my[1] = wd;
         else if (ws == 4'd10) mbp = wd;
         else if (ws == 4'd11) mbv = wd;
         else if (ws == 4'd12) mmd = wd;
      end
   endtask

   task automatic load(input logic [3:0] ws, input logic [15:0] wd);
      cyc(1'b1, ws, wd, 1'b0, 3'd0, 3'd0, 2'd0, 1'b0, 7'd0);
   endtask

   task automatic peek(input logic [2:0] p);
      cyc(1'b0, 4'd0, 16'd0, 1'b1, 3'd0, p, 2'd0, 1'b0, 7'd0);
   endtask

   task automatic peek_all();
      for (int i = 0; i < 8; i++) peek(3'(i));
      cyc(1'b0, 4'd0, 16'd0, 1'b1, 3'd2, 3'd0, 2'd0, 1'b0, 7'd0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 8; i++) mx[i] = '0;
      my[0] = '0; my[1] = '0; mbp = '0; mbv = '0; mmd = '0;
      void'($urandom(32'h5eed_0042));
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R1: reset state read back through the address output
      peek_all();
      cyc(1'b0, 4'd0, 16'd0, 1'b0, 3'd0, 3'd0, 2'd0, 1'b0, 7'd0);

      // R2: each immediate step code
      load(4'd1, 16'h0000);
      cyc(1'b0, 0, 0, 1'b1, 3'd0, 3'd1, 2'b10, 1'b0, 7'd0);
      cyc(1'b0, 0, 0, 1'b1, 3'd0, 3'd1, 2'b11, 1'b0, 7'd0);
      cyc(1'b0, 0, 0, 1'b1, 3'd0, 3'd1, 2'b01, 1'b0, 7'd0);
      peek(3'd1);

      // R3: signed step register, wraps modulo 2^16
      load(4'd9, 16'hFFF0);
      load(4'd2, 16'h0008);
      cyc(1'b0, 0, 0, 1'b1, 3'd1, 3'd2, 2'd0, 1'b1, 7'd0);
      peek(3'd2);

      // R4: direct addressing with carry out of 16 bits
      load(4'd10, 16'hFFF0);
      cyc(1'b0, 0, 0, 1'b1, 3'd2, 3'd0, 2'd0, 1'b0, 7'h7F);
      cyc(1'b0, 0, 0, 1'b1, 3'd2, 3'd0, 2'd0, 1'b0, 7'h05);

      // R5: ring edges in both directions
      load(4'd11, 16'h0100);
      load(4'd12, 16'h0008);
      load(4'd3, 16'h0107);
      cyc(1'b0, 0, 0, 1'b1, 3'd3, 3'd3, 2'b01, 1'b0, 7'd0);
      peek(3'd3);
      cyc(1'b0, 0, 0, 1'b1, 3'd3, 3'd3, 2'b10, 1'b0, 7'd0);
      peek(3'd3);
      load(4'd8, 16'hFFFD);
      cyc(1'b0, 0, 0, 1'b1, 3'd4, 3'd3, 2'd0, 1'b0, 7'd0);
      peek(3'd3);

      // R6: zero ring length holds the pointer
      load(4'd12, 16'h0000);
      cyc(1'b0, 0, 0, 1'b1, 3'd3, 3'd3, 2'b01, 1'b0, 7'd0);
      peek(3'd3);

      // R8: load beats advance on the same pointer
      cyc(1'b1, 4'd4, 16'hBEEF, 1'b1, 3'd0, 3'd4, 2'b01, 1'b0, 7'd0);
      peek(3'd4);

      // R7 / R9: unused write codes, idle and reserved modes change nothing
      load(4'd13, 16'h1234);
      load(4'd15, 16'h4321);
      cyc(1'b0, 0, 0, 1'b1, 3'd6, 3'd4, 2'b01, 1'b0, 7'd0);
      cyc(1'b0, 0, 0, 1'b0, 3'd0, 3'd4, 2'b01, 1'b0, 7'd0);
      peek_all();

      // Random phase, small ring lengths favoured
      for (int n = 0; n < 4000; n++) begin
         logic [3:0]  ws;
         logic [15:0] wd;
         ws = 4'($urandom_range(0, 15));
         wd = 16'($urandom);
         if (ws == 4'd12 && $urandom_range(0, 3) != 0) wd = 16'($urandom_range(0, 12));
         if (ws < 4'd8 && $urandom_range(0, 1) == 1) wd = mbv + 16'($urandom_range(0, 12));
         cyc($urandom_range(0, 3) == 0, ws, wd, $urandom_range(0, 5) != 0,
             3'($urandom_range(0, 7)), 3'($urandom_range(0, 7)), 2'($urandom),
             1'($urandom), 7'($urandom));
      end
      peek_all();

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule